// File: doc/BRIEF.md
# Butterfly Sum/Difference Register Unit

This block pairs a sixteen-entry register file of 32-bit words with an execution path for one radix-2 butterfly step. A single issue reads two source registers and writes both their sum and their difference, on the same clock edge, into two destination registers. Each word holds a packed complex integer: the real part in bits [31:16] and the imaginary part in bits [15:0]. Both 16-bit lanes are added and subtracted in parallel. A saturate control selects between wrap-around lanes and lanes clamped to the signed 16-bit range.

Register choice is restricted so that the operand field needs only 8 bits. The first source comes from registers 8–11 and the second from 12–15. The sum goes to registers 0–3 and the difference to registers 4–7. Each of the four fields is therefore a 2-bit index. The unit accepts a request naming four full register numbers, packs it into the 8-bit field, and rejects any request that the short form cannot express. This includes the reversed subtraction order. A rejected request raises a one-cycle strobe and writes nothing. A plain load port fills registers, and a combinational read port exposes any register.

Top module: `bfly_unit`

## Requirements
- R1: After reset, all sixteen registers read as zero and `illegal_pulse` is low.
- R2: The request `bf_req` carries four 4-bit register numbers: first source in [15:12], second source in [11:8], sum destination in [7:4], difference destination in [3:0]. When `bf_valid` is high with a legal request, both results are written on that clock edge, and `rd_data` shows them from the next cycle on.
- R3: With `sat_en` low, each 16-bit lane wraps modulo 2^16, and no carry or borrow passes from the imaginary lane [15:0] into the real lane [31:16].
- R4: With `sat_en` high, each lane result is clamped to the signed range -32768..32767.
- R5: The difference is always first source minus second source. The first source must be register 8–11 and the second register 12–15.
- R6: A valid request whose sources lie outside those groups, including the swapped order, sets `illegal_pulse` high for exactly the following cycle and writes no register.
- R7: A valid request whose sum destination is outside 0–3, or whose difference destination is outside 4–7, is treated as illegal in the same way as R6.
- R8: When `ld_en` is high, `ld_data` is written to register `ld_addr` on the clock edge.
- R9: If a load and a butterfly result target the same register in one cycle, the butterfly result is stored. A load to any other register in that cycle still takes effect. Sources are read before the edge, so a same-cycle load to a source register does not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bf_valid | input | 1 | Issue a butterfly request this cycle |
| bf_req | input | 16 | Four register numbers: src A, src B, sum dst, diff dst |
| sat_en | input | 1 | 1 = clamp lanes, 0 = wrap lanes |
| ld_en | input | 1 | Load enable |
| ld_addr | input | 4 | Register written by the load |
| ld_data | input | 32 | Load value |
| rd_addr | input | 4 | Register selected for read-out |
| rd_data | output | 32 | Contents of register `rd_addr` |
| illegal_pulse | output | 1 | One-cycle strobe after a rejected request |

## Verification
A load and a butterfly write can land on the same clock edge, either on one register or on different ones. The bench provokes this by driving `ld_en` together with a legal request in three ways: the load address equals a destination, the load address is unrelated, and the load address is one of the sources. It then reads every register back and compares each one against a model in which the butterfly wins on a shared destination and the sources keep their pre-edge values.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
  localparam int LANE_W = 16;
  localparam int IDX_W  = 2;
  // fixed register groups, indexed by the upper address bits
  localparam int GRP_SUM  = 0;
  localparam int GRP_DIFF = 1;
  localparam int GRP_A    = 2;
  localparam int GRP_B    = 3;

  typedef logic [LANE_W-1:0] lane_t;

  typedef struct packed {
    logic [IDX_W-1:0] src_a;
    logic [IDX_W-1:0] src_b;
    logic [IDX_W-1:0] dst_sum;
    logic [IDX_W-1:0] dst_diff;
  } bf_field_t;

  function automatic lane_t lane_fit(logic signed [LANE_W:0] wide, logic sat);
    lane_t res;
    res = wide[LANE_W-1:0];
    if (sat && (wide[LANE_W] != wide[LANE_W-1]))
      res = wide[LANE_W] ? {1'b1, {(LANE_W-1){1'b0}}} : {1'b0, {(LANE_W-1){1'b1}}};
    return res;
  endfunction

  function automatic lane_t lane_add(lane_t a, lane_t b, logic sat);
    logic signed [LANE_W:0] w;
    w = $signed({a[LANE_W-1], a}) + $signed({b[LANE_W-1], b});
    return lane_fit(w, sat);
  endfunction

  function automatic lane_t lane_sub(lane_t a, lane_t b, logic sat);
    logic signed [LANE_W:0] w;
    w = $signed({a[LANE_W-1], a}) - $signed({b[LANE_W-1], b});
    return lane_fit(w, sat);
  endfunction
endpackage

// File: rtl/bfly_encode.sv
module bfly_encode
  import bfly_pkg::*;
#(
  parameter int REG_AW = 4
) (
  input  logic [4*REG_AW-1:0] req,
  output bf_field_t           field,
  output logic                legal
);
  localparam int GRP_W = REG_AW - IDX_W;

  logic [3:0]       grp_ok;
  logic [IDX_W-1:0] idx [4];

  for (genvar k = 0; k < 4; k++) begin : g_slot
    localparam int EXP_G = (k == 0) ? GRP_A : (k == 1) ? GRP_B : (k == 2) ? GRP_SUM : GRP_DIFF;
    logic [REG_AW-1:0] regno;
    assign regno     = req[(3-k)*REG_AW +: REG_AW];
    assign idx[k]    = regno[IDX_W-1:0];
    assign grp_ok[k] = (regno[REG_AW-1:IDX_W] == GRP_W'(EXP_G));
  end

  assign legal = &grp_ok;
  assign field = '{src_a: idx[0], src_b: idx[1], dst_sum: idx[2], dst_diff: idx[3]};
endmodule

// File: rtl/bfly_decode.sv
module bfly_decode
  import bfly_pkg::*;
#(
  parameter int REG_AW = 4
) (
  input  bf_field_t         field,
  output logic [REG_AW-1:0] a_addr,
  output logic [REG_AW-1:0] b_addr,
  output logic [REG_AW-1:0] sum_addr,
  output logic [REG_AW-1:0] diff_addr
);
  localparam int GRP_W = REG_AW - IDX_W;

  assign a_addr    = {GRP_W'(GRP_A),    field.src_a};
  assign b_addr    = {GRP_W'(GRP_B),    field.src_b};
  assign sum_addr  = {GRP_W'(GRP_SUM),  field.dst_sum};
  assign diff_addr = {GRP_W'(GRP_DIFF), field.dst_diff};
endmodule

// File: rtl/bfly_lane_alu.sv
module bfly_lane_alu
  import bfly_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic              sat,
  output logic [DATA_W-1:0] sum,
  output logic [DATA_W-1:0] diff
);
  localparam int LANES = DATA_W / LANE_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign sum [l*LANE_W +: LANE_W] = lane_add(op_a[l*LANE_W +: LANE_W], op_b[l*LANE_W +: LANE_W], sat);
    assign diff[l*LANE_W +: LANE_W] = lane_sub(op_a[l*LANE_W +: LANE_W], op_b[l*LANE_W +: LANE_W], sat);
  end
endmodule

// File: rtl/bfly_regfile.sv
module bfly_regfile #(
  parameter int DATA_W = 32,
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bf_we,
  input  logic [REG_AW-1:0] sum_addr,
  input  logic [REG_AW-1:0] diff_addr,
  input  logic [DATA_W-1:0] sum_data,
  input  logic [DATA_W-1:0] diff_data,
  input  logic              ld_we,
  input  logic [REG_AW-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [REG_AW-1:0] ra_addr,
  input  logic [REG_AW-1:0] rb_addr,
  input  logic [REG_AW-1:0] rx_addr,
  output logic [DATA_W-1:0] ra_data,
  output logic [DATA_W-1:0] rb_data,
  output logic [DATA_W-1:0] rx_data
);
  localparam int NREG = 1 << REG_AW;

  logic [DATA_W-1:0] rf [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) rf[r] <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (bf_we && sum_addr == REG_AW'(r))       rf[r] <= sum_data;
        else if (bf_we && diff_addr == REG_AW'(r)) rf[r] <= diff_data;
        else if (ld_we && ld_addr == REG_AW'(r))   rf[r] <= ld_data;
      end
    end
  end

  assign ra_data = rf[ra_addr];
  assign rb_data = rf[rb_addr];
  assign rx_data = rf[rx_addr];

  // R2: both results are present one edge after the write
  a_r2_sum_lands: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(bf_we)) |-> rf[$past(sum_addr)] == $past(sum_data));
  a_r2_diff_lands: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(bf_we)) |-> rf[$past(diff_addr)] == $past(diff_data));
  // R8/R9: a load lands unless a butterfly result claims the register
  a_r8_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ld_we) &&
     !($past(bf_we) && ($past(ld_addr) == $past(sum_addr) || $past(ld_addr) == $past(diff_addr))))
    |-> rf[$past(ld_addr)] == $past(ld_data));
endmodule

// File: rtl/bfly_unit.sv
module bfly_unit
  import bfly_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_AW = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bf_valid,
  input  logic [4*REG_AW-1:0] bf_req,
  input  logic                sat_en,
  input  logic                ld_en,
  input  logic [REG_AW-1:0]   ld_addr,
  input  logic [DATA_W-1:0]   ld_data,
  input  logic [REG_AW-1:0]   rd_addr,
  output logic [DATA_W-1:0]   rd_data,
  output logic                illegal_pulse
);
  localparam int GRP_W = REG_AW - IDX_W;

  bf_field_t         field;
  logic              req_legal;
  logic              bf_we;
  logic [REG_AW-1:0] a_addr, b_addr, sum_addr, diff_addr;
  logic [DATA_W-1:0] a_data, b_data, sum_data, diff_data;
  logic              illegal_q;

  bfly_encode #(.REG_AW(REG_AW)) u_enc (
    .req(bf_req), .field(field), .legal(req_legal)
  );

  bfly_decode #(.REG_AW(REG_AW)) u_dec (
    .field(field), .a_addr(a_addr), .b_addr(b_addr),
    .sum_addr(sum_addr), .diff_addr(diff_addr)
  );

  bfly_lane_alu #(.DATA_W(DATA_W)) u_alu (
    .op_a(a_data), .op_b(b_data), .sat(sat_en), .sum(sum_data), .diff(diff_data)
  );

  assign bf_we = bf_valid & req_legal;

  bfly_regfile #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .bf_we(bf_we), .sum_addr(sum_addr), .diff_addr(diff_addr),
    .sum_data(sum_data), .diff_data(diff_data),
    .ld_we(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .ra_addr(a_addr), .rb_addr(b_addr), .rx_addr(rd_addr),
    .ra_data(a_data), .rb_data(b_data), .rx_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) illegal_q <= 1'b0;
    else        illegal_q <= bf_valid & ~req_legal;
  end

  assign illegal_pulse = illegal_q;

  // R6: the strobe only follows a rejected issue
  a_r6_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_pulse |-> $past(bf_valid) && !$past(req_legal));
  // R6: a rejected issue in one cycle raises the strobe in the next
  a_r6_pulse_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (bf_valid && !req_legal) |=> illegal_pulse);
  // R5: decoded sources stay in their fixed groups
  a_r5_src_groups: assert property (@(posedge clk) disable iff (!rst_n)
    bf_we |-> (a_addr[REG_AW-1:IDX_W] == GRP_W'(GRP_A)) && (b_addr[REG_AW-1:IDX_W] == GRP_W'(GRP_B))
              && (a_addr == bf_req[4*REG_AW-1 -: REG_AW]));
  // R7: decoded destinations match the request and lie in their groups
  a_r7_dst_groups: assert property (@(posedge clk) disable iff (!rst_n)
    bf_we |-> (sum_addr[REG_AW-1:IDX_W] == GRP_W'(GRP_SUM)) && (diff_addr[REG_AW-1:IDX_W] == GRP_W'(GRP_DIFF))
              && (diff_addr == bf_req[REG_AW-1:0]));
endmodule

// File: tb/bfly_unit_bench.sv
`timescale 1ns/100ps
module bfly_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bf_valid = 1'b0;
  logic [15:0] bf_req = '0;
  logic        sat_en = 1'b0;
  logic        ld_en = 1'b0;
  logic [3:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        illegal_pulse;

  bfly_unit u_bfly_unit (
    .clk(clk), .rst_n(rst_n), .bf_valid(bf_valid), .bf_req(bf_req), .sat_en(sat_en),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .illegal_pulse(illegal_pulse)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    int          kind;   // 0 register read, 1 strobe level
    int          addr;
    logic [31:0] val;
    string       tag;
  } exp_t;

  exp_t        sb [$];
  logic [31:0] model [16];
  int          checks = 0;
  int          errors = 0;
  bit          mon_busy = 1'b0;
  bit          done = 1'b0;

  function automatic logic [15:0] ref_lane(logic [15:0] x, logic [15:0] y, bit sub, bit sat);
    int r;
    r = sub ? (int'($signed(x)) - int'($signed(y))) : (int'($signed(x)) + int'($signed(y)));
    if (sat && r > 32767)  r = 32767;
    if (sat && r < -32768) r = -32768;
    return r[15:0];
  endfunction

  function automatic logic [31:0] ref_word(logic [31:0] x, logic [31:0] y, bit sub, bit sat);
    return {ref_lane(x[31:16], y[31:16], sub, sat), ref_lane(x[15:0], y[15:0], sub, sat)};
  endfunction

  task automatic push_all(string tag);
    for (int r = 0; r < 16; r++) sb.push_back('{0, r, model[r], tag});
  endtask

  task automatic drain();
    wait (sb.size() == 0 && !mon_busy);
  endtask

  // driver: one issue, then expected strobe and full register image
  task automatic issue(bit v, int a, int b, int s, int d, bit sat,
                       bit ldon, int la, logic [31:0] ldv, string tag);
    bit          legal;
    logic [31:0] sv, dv;
    legal = v && a >= 8 && a <= 11 && b >= 12 && b <= 15 && s >= 0 && s <= 3 && d >= 4 && d <= 7;
    if (legal) begin
      sv = ref_word(model[a], model[b], 1'b0, sat);
      dv = ref_word(model[a], model[b], 1'b1, sat);
    end
    @(negedge clk);
    bf_valid = v;
    bf_req   = {4'(a), 4'(b), 4'(s), 4'(d)};
    sat_en   = sat;
    ld_en    = ldon;
    ld_addr  = 4'(la);
    ld_data  = ldv;
    @(negedge clk);
    bf_valid = 1'b0;
    ld_en    = 1'b0;
    if (ldon) model[la] = ldv;
    if (legal) begin
      model[s] = sv;
      model[d] = dv;
    end
    sb.push_back('{1, 0, {31'd0, v && !legal}, tag});
    push_all(tag);
    drain();
    @(negedge clk);
    sb.push_back('{1, 0, 32'd0, {tag, " strobe drop"}});
    drain();
  endtask

  // monitor: pops expected items and compares against the ports
  initial begin
    exp_t e;
    forever begin
      wait (sb.size() > 0);
      mon_busy = 1'b1;
      e = sb.pop_front();
      if (e.kind == 1) begin
        checks++;
        if (illegal_pulse !== e.val[0]) begin
          errors++;
          $display("FAIL %s illegal_pulse actual %b expected %b", e.tag, illegal_pulse, e.val[0]);
        end
      end else begin
        rd_addr = 4'(e.addr);
        #0.1;
        checks++;
        if (rd_data !== e.val) begin
          errors++;
          $display("FAIL %s reg%0d actual %h expected %h", e.tag, e.addr, rd_data, e.val);
        end
      end
      mon_busy = 1'b0;
    end
  end

  initial begin
    for (int r = 0; r < 16; r++) model[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    sb.push_back('{1, 0, 32'd0, "R1"});
    push_all("R1");
    drain();

    // R8: fill the source groups through the load port
    issue(0, 0, 0, 0, 0, 0, 1,  8, 32'h0003_0005, "R8");
    issue(0, 0, 0, 0, 0, 0, 1,  9, 32'h7FFF_FFFF, "R8");
    issue(0, 0, 0, 0, 0, 0, 1, 10, 32'h8000_0010, "R8");
    issue(0, 0, 0, 0, 0, 0, 1, 11, 32'h1234_F000, "R8");
    issue(0, 0, 0, 0, 0, 0, 1, 12, 32'h0001_0002, "R8");
    issue(0, 0, 0, 0, 0, 0, 1, 13, 32'h0001_0001, "R8");
    issue(0, 0, 0, 0, 0, 0, 1, 14, 32'h0001_7FFF, "R8");
    issue(0, 0, 0, 0, 0, 0, 1, 15, 32'hFFFF_8000, "R8");

    // R2/R5: plain dual write, difference is first minus second
    issue(1,  8, 12, 0, 4, 0, 0, 0, '0, "R2 R5");
    // R3: real lane wraps, imaginary lane carry does not cross
    issue(1,  9, 13, 1, 5, 0, 0, 0, '0, "R3");
    issue(1, 10, 14, 2, 6, 0, 0, 0, '0, "R3");
    // R4: clamp on overflow in both directions
    issue(1,  9, 13, 3, 7, 1, 0, 0, '0, "R4");
    issue(1, 10, 14, 2, 6, 1, 0, 0, '0, "R4");
    issue(1, 11, 15, 0, 4, 1, 0, 0, '0, "R4");

    // R6: swapped order and out-of-group sources are rejected
    issue(1, 12,  8, 0, 4, 0, 0, 0, '0, "R6");
    issue(1,  9, 10, 1, 5, 0, 0, 0, '0, "R6");
    // R7: destinations outside their groups are rejected
    issue(1,  8, 12, 5, 4, 0, 0, 0, '0, "R7");
    issue(1,  8, 12, 0, 8, 0, 0, 0, '0, "R7");

    // R9: load and butterfly on the same edge
    issue(1, 11, 15, 2, 6, 0, 1, 2,  32'hDEAD_BEEF, "R9");
    issue(1,  8, 13, 1, 5, 0, 1, 3,  32'hCAFE_0001, "R9");
    issue(1, 11, 12, 0, 7, 0, 1, 11, 32'h0100_0100, "R9");
    issue(1, 11, 12, 3, 4, 0, 0, 0, '0, "R2");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule